// File: doc/BRIEF.md
# Mixed-Policy Control Register Bank

This block is a small bank of control and status registers on a plain synchronous register bus: one address, a write strobe with write data, a read strobe, and read data one cycle after the strobe. Every bit of every register has its own access policy. The policy is taken from a fixed table in the package. The policies are: plain read/write, write-only, read-only (follows a hardware input), discarded, constant zero, constant one, clear-on-writing-one, clear-on-writing-zero, and capture-and-hold until read.

Hardware drives the bank through three inputs. `hw_val` supplies the values that read-only and capture bits take. `hw_set` carries the set events for the two clear-by-write policies. `hw_cap` gives one capture strobe per register. Every stored bit is also driven out on `fld_q` so that the logic around the bank can use it.

The default table has four 8-bit registers at addresses 0 to 3. In every flat vector, register n occupies bits [8n+7:8n].

Top module: `regbank_mixed`

## Requirements
- R1: Address 0, bits 3:0 are read/write. A write stores `bus_wdata[3:0]`. Reads return the stored value, and `fld_q[3:0]` shows it from the cycle after the write.
- R2: Address 0, bits 5:4 are write-only. A write stores the data and shows it on `fld_q[5:4]`. A read returns 0 in those bits.
- R3: Address 1, bits 3:0 are read-only. Each cycle they sample `hw_val[11:8]`, and a read returns the sampled value. Bus writes have no effect on them.
- R4: Address 1, bits 7:4 discard all writes. They read as 0 and show 0 on `fld_q[15:12]`.
- R5: Address 0, bit 6 always reads 1 and bit 7 always reads 0. Neither bit stores anything.
- R6: Address 2, bits 3:0 are clear-on-one. A `hw_set` bit sets its bit. A bus write of 1 clears it, and a write of 0 leaves it unchanged. When a set and a clear arrive in the same cycle, the set wins.
- R7: Address 2, bits 7:4 are clear-on-zero. A `hw_set` bit sets its bit. A bus write of 0 clears it, and a write of 1 leaves it unchanged. When a set and a clear arrive in the same cycle, the set wins.
- R8: Address 3 is a capture-and-hold register. If it is not holding, a `hw_cap[3]` pulse loads `hw_val[31:24]` and the register starts holding. While it holds, further captures are ignored. A read returns the held value, clears the register to 0 and releases the hold. A capture in the same cycle as that read is still ignored, and the next cycle may capture. If the register is not holding, a capture in the same cycle as a read is taken.
- R9: `bus_rdata` carries the addressed value in the cycle after `bus_rd_en`. In any cycle after one without a read strobe, it is 0.
- R10: Addresses 4 to 7 map to no register. Reading them returns 0, and writing them changes nothing.
- R11: After reset, every stored bit and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| hw_val | input | 32 | Hardware values for read-only and capture bits |
| hw_set | input | 32 | Set events for clear-by-write bits |
| hw_cap | input | 4 | Capture strobe per register |
| fld_q | output | 32 | Stored value of every bit |

## Verification
A wrong stored bit shows up on `fld_q` on the clock edge after the write or event that caused it. It shows up on `bus_rdata` one edge after the next read of that register. A capture register that keeps its hold flag too long, or drops it too early, gives itself away in the capture after the read. The sweeps therefore look at both `fld_q` and read data after every write pattern of each register. The capture sequences check the register in the cycle right after each read.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [3:0] {
    ACC_RW, ACC_RO, ACC_WO, ACC_IGN, ACC_RAZ, ACC_RAO, ACC_W1C, ACC_W0C, ACC_RC
  } access_e;

  // Fixed field table: policy of bit b in register r.
  function automatic access_e field_policy(int r, int b);
    case (r)
      0: begin
        if (b < 4)       return ACC_RW;
        else if (b < 6)  return ACC_WO;
        else if (b == 6) return ACC_RAO;
        else             return ACC_RAZ;
      end
      1: return (b < 4) ? ACC_RO : ACC_IGN;
      2: return (b < 4) ? ACC_W1C : ACC_W0C;
      3: return ACC_RC;
      default: return ACC_IGN;
    endcase
  endfunction

  function automatic logic [63:0] policy_mask(int r, int w, access_e p);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < w; b++)
      if (field_policy(r, b) == p) m[b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/rb_addr_decode.sv
module rb_addr_decode #(
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit
);
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) sel[i] = 1'b1;
    hit = |sel;
  end

  // R10
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel) && (hit == (int'(addr) < NUM_REGS)));
endmodule

// File: rtl/rb_reg.sv
module rb_reg
  import regbank_pkg::*;
#(
  parameter int REG_IDX = 0,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_val,
  input  logic [DATA_W-1:0] hw_set,
  input  logic              hw_cap,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] rd_view
);
  localparam logic [DATA_W-1:0] RC_M = DATA_W'(policy_mask(REG_IDX, DATA_W, ACC_RC));
  localparam logic [DATA_W-1:0] RO_M = DATA_W'(policy_mask(REG_IDX, DATA_W, ACC_RO));

  logic lock;
  logic cap_ok;

  generate
    if (RC_M != '0) begin : g_lock
      assign cap_ok = hw_cap && !lock;
      always_ff @(posedge clk) begin
        if (rst)         lock <= 1'b0;
        else if (cap_ok) lock <= 1'b1;
        else if (rd_sel) lock <= 1'b0;
      end
      // R8
      rc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && !rd_sel) |=> ((q & RC_M) == $past(q & RC_M)));
    end else begin : g_nolock
      assign cap_ok = 1'b0;
      assign lock   = 1'b0;
    end
  endgenerate

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam access_e P = field_policy(REG_IDX, b);
      logic bit_q;
      if (P == ACC_RW || P == ACC_WO) begin : g_store
        always_ff @(posedge clk) begin
          if (rst)         bit_q <= 1'b0;
          else if (wr_sel) bit_q <= wdata[b];
        end
        assign rd_view[b] = (P == ACC_RW) ? bit_q : 1'b0;
      end else if (P == ACC_RO) begin : g_ro
        always_ff @(posedge clk) begin
          if (rst) bit_q <= 1'b0;
          else     bit_q <= hw_val[b];
        end
        assign rd_view[b] = bit_q;
      end else if (P == ACC_W1C || P == ACC_W0C) begin : g_wc
        logic clr;
        assign clr = wr_sel && (wdata[b] == (P == ACC_W1C));
        always_ff @(posedge clk) begin
          if (rst)            bit_q <= 1'b0;
          else if (hw_set[b]) bit_q <= 1'b1;
          else if (clr)       bit_q <= 1'b0;
        end
        assign rd_view[b] = bit_q;
        // R6 R7
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
          hw_set[b] |=> bit_q);
      end else if (P == ACC_RC) begin : g_rc
        always_ff @(posedge clk) begin
          if (rst)         bit_q <= 1'b0;
          else if (cap_ok) bit_q <= hw_val[b];
          else if (rd_sel) bit_q <= 1'b0;
        end
        assign rd_view[b] = bit_q;
      end else begin : g_const
        assign bit_q      = 1'b0;
        assign rd_view[b] = (P == ACC_RAO);
      end
      assign q[b] = bit_q;
    end
  endgenerate

  // R3
  ro_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & RO_M) == ($past(hw_val) & RO_M)));
endmodule

// File: rtl/rb_read_port.sv
module rb_read_port #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [NUM_REGS-1:0]        sel,
  input  logic [NUM_REGS*DATA_W-1:0] views,
  output logic [DATA_W-1:0]          rdata
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel[i]) mux = mux | views[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mux;
    else            rdata <= '0;
  end

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

// File: rtl/regbank_mixed.sv
module regbank_mixed
  import regbank_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr_en,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_rd_en,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_REGS*DATA_W-1:0] hw_val,
  input  logic [NUM_REGS*DATA_W-1:0] hw_set,
  input  logic [NUM_REGS-1:0]        hw_cap,
  output logic [NUM_REGS*DATA_W-1:0] fld_q
);
  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic [NUM_REGS-1:0] sel;
  logic                hit;
  logic [FLAT_W-1:0]   views;

  rb_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .sel(sel), .hit(hit)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      rb_reg #(.REG_IDX(i), .DATA_W(DATA_W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (sel[i] && bus_wr_en),
        .rd_sel (sel[i] && bus_rd_en),
        .wdata  (bus_wdata),
        .hw_val (hw_val[i*DATA_W +: DATA_W]),
        .hw_set (hw_set[i*DATA_W +: DATA_W]),
        .hw_cap (hw_cap[i]),
        .q      (fld_q[i*DATA_W +: DATA_W]),
        .rd_view(views[i*DATA_W +: DATA_W])
      );
    end
  endgenerate

  rb_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd_en), .sel(sel),
    .views(views), .rdata(bus_rdata)
  );

  function automatic logic [DATA_W-1:0] ones_of(logic [ADDR_W-1:0] a);
    return DATA_W'(policy_mask(int'(a), DATA_W, ACC_RAO));
  endfunction

  function automatic logic [DATA_W-1:0] zeros_of(logic [ADDR_W-1:0] a);
    return DATA_W'(policy_mask(int'(a), DATA_W, ACC_RAZ) |
                   policy_mask(int'(a), DATA_W, ACC_WO)  |
                   policy_mask(int'(a), DATA_W, ACC_IGN));
  endfunction

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && !hit) |=> (bus_rdata == '0));

  // R5
  const_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && hit) |=> ((bus_rdata & ones_of($past(bus_addr))) == ones_of($past(bus_addr))));

  // R2 R4
  quiet_bits_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd_en |=> ((bus_rdata & zeros_of($past(bus_addr))) == '0));
endmodule

// File: tb/regbank_mixed_bench.sv
module regbank_mixed_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd_en = 1'b0;
  logic [7:0]  bus_rdata;
  logic [31:0] hw_val = '0;
  logic [31:0] hw_set = '0;
  logic [3:0]  hw_cap = '0;
  logic [31:0] fld_q;

  int errors = 0;
  int checks = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  regbank_mixed u_regbank_mixed (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .hw_val(hw_val), .hw_set(hw_set), .hw_cap(hw_cap), .fld_q(fld_q)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    v = bus_rdata;
  endtask

  task automatic cap3(logic [7:0] d);
    @(negedge clk);
    hw_val[31:24] = d; hw_cap[3] = 1'b1;
    @(negedge clk);
    hw_cap[3] = 1'b0;
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 fld_q", fld_q, 32'h0);
    check("R11 rdata", {24'h0, bus_rdata}, 32'h0);

    // R1 R2 R5 sweep of address 0
    for (int w = 0; w < 256; w++) begin
      wr(3'd0, 8'(w));
      check("R1 R2 fld_q", {24'h0, fld_q[7:0]}, 32'(w & 8'h3F));
      rd(3'd0, v);
      check("R1 R2 R5 read", {24'h0, v}, 32'((w & 8'h0F) | 8'h40));
    end

    // R3 R4 sweep of address 1
    for (int w = 0; w < 256; w++) begin
      @(negedge clk);
      hw_val[11:8] = 4'(w >> 4);
      wr(3'd1, 8'(w));
      check("R3 R4 fld_q", {24'h0, fld_q[15:8]}, 32'(w >> 4));
      rd(3'd1, v);
      check("R3 R4 read", {24'h0, v}, 32'(w >> 4));
    end

    // R6 R7 sweep of address 2
    for (int w = 0; w < 256; w++) begin
      @(negedge clk);
      hw_set[23:16] = 8'hFF;
      @(negedge clk);
      hw_set[23:16] = 8'h00;
      wr(3'd2, 8'(w));
      check("R6 R7 fld_q", {24'h0, fld_q[23:16]}, 32'((w & 8'hF0) | (~w & 8'h0F)));
      rd(3'd2, v);
      check("R6 R7 read", {24'h0, v}, 32'((w & 8'hF0) | (~w & 8'h0F)));
    end

    // R6 R7 set wins over clear in the same cycle
    wr(3'd2, 8'h0F);
    check("R6 R7 cleared", {24'h0, fld_q[23:16]}, 32'h0);
    @(negedge clk);
    bus_addr = 3'd2; bus_wdata = 8'h01; bus_wr_en = 1'b1;
    hw_set[16] = 1'b1; hw_set[20] = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; hw_set = '0;
    check("R6 R7 set wins", {24'h0, fld_q[23:16]}, 32'h11);

    // R8 capture and hold
    cap3(8'hA5);
    check("R8 capture", {24'h0, fld_q[31:24]}, 32'hA5);
    cap3(8'h3C);
    check("R8 held", {24'h0, fld_q[31:24]}, 32'hA5);
    rd(3'd3, v);
    check("R8 read held", {24'h0, v}, 32'hA5);
    check("R8 cleared", {24'h0, fld_q[31:24]}, 32'h0);
    cap3(8'h5A);
    @(negedge clk);
    bus_addr = 3'd3; bus_rd_en = 1'b1; hw_val[31:24] = 8'h77; hw_cap[3] = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0; hw_cap[3] = 1'b0;
    check("R8 read with capture locked", {24'h0, bus_rdata}, 32'h5A);
    check("R8 capture blocked", {24'h0, fld_q[31:24]}, 32'h0);
    cap3(8'h77);
    check("R8 capture after read", {24'h0, fld_q[31:24]}, 32'h77);
    rd(3'd3, v);
    check("R8 second read", {24'h0, v}, 32'h77);
    @(negedge clk);
    bus_addr = 3'd3; bus_rd_en = 1'b1; hw_val[31:24] = 8'h99; hw_cap[3] = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0; hw_cap[3] = 1'b0;
    check("R8 read unlocked", {24'h0, bus_rdata}, 32'h0);
    check("R8 capture taken", {24'h0, fld_q[31:24]}, 32'h99);

    // R9 no strobe gives zero
    @(negedge clk);
    check("R9 idle", {24'h0, bus_rdata}, 32'h0);

    // R10 unmapped addresses
    for (int a = 4; a < 8; a++) begin
      snap = fld_q;
      wr(3'(a), 8'hFF);
      check("R10 write", fld_q, snap);
      rd(3'(a), v);
      check("R10 read", {24'h0, v}, 32'h0);
    end

    finish_run();
  end
endmodule